// File: doc/BRIEF.md
# Bit-Serial Clock and Scratch-RAM Slave

This block is a small serial slave that a host reaches by toggling three register bits: a select line, a serial clock and a data line. Every access is one 16-bit frame. The first eight bits carry a command byte and the last eight carry a data byte, both most significant bit first. A read command drives its answer back on the serial output during the second half of the same frame. The block holds 32 bytes of scratch RAM, a status byte, a fixed control byte and a BCD calendar clock that advances on a one-second tick input.

Write commands take effect once the sixteenth bit has been received. A status-acknowledge command clears the two event flags. Those flags drive an interrupt line that signals alarm or power events. A separate event input can raise one of the flags. All pins are sampled in the core clock domain. A falling serial-clock edge is found by comparing the pin with its value one core cycle earlier.

Top module: `serial_clock_nvram`

## Requirements
- R1: A bit is taken only on a falling edge of `sclk` while `ce` is high. The core sees the edge one cycle after the pin falls. Bits 0-7 of a frame shift into the command and bits 8-15 shift into the data byte, both MSB first.
- R2: While `ce` is low, the bit counter, the command and the data byte stay cleared. A frame cut short by dropping `ce` changes no state.
- R3: Commands 0x00-0x1F return RAM[command]. During bits 8-15 `sdo_en` is high and `sdo` carries the byte MSB first. `sdo_en` is low at every other time.
- R4: Commands 0x80-0x9F write the received data byte to RAM[command-0x80] on the sixteenth falling edge.
- R5: After reset the status byte is 0x90 and is read with command 0x30. Command 0x31 returns the control byte, whose default is 0x00. RAM resets to 0x00.
- R6: Command 0xB1 with data bit 2 set clears status bits 4 and 3. With data bit 2 clear, 0xB1 leaves the status unchanged. `pwr_evt` sets status bit 3. `irq` equals status bit 4 OR status bit 3.
- R7: Time reads return BCD values: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day, 0x25 month (1-12), 0x26 year within the century.
- R8: Commands 0x23 and 0x27-0x2F return 0x00. Any command outside the read and write ranges drives nothing and changes no state.
- R9: Each `sec_tick` pulse advances the BCD chain. Seconds and minutes wrap from 59 to 00, hours from 23 to 00, the day from 31 to 01, the month from 12 to 01 and the year from 99 to 00. Each field carries into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Frame select from the host |
| sclk | input | 1 | Serial clock from the host; bits are taken on its falling edge |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | High while the block drives read data |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_evt | input | 1 | One-cycle event that sets status bit 3 |
| irq | output | 1 | Event interrupt, high while status bit 4 or 3 is set |

## Verification
Properties checked on every cycle:
- The bit counter never passes 16 and only ever steps by one.
- A low `ce` leaves the counter and the command cleared.
- `sdo_en` is never high outside the data half of a frame.
- Every time field stays a legal BCD value inside its range.
- An acknowledge frame drops `irq` unless an event arrives in the same cycle.

Scenarios only the bench can show:
- Which byte each command returns.
- Writes at both ends of the RAM range.
- An aborted frame that must not write.
- Full carry through every calendar field.
- The difference between an acknowledge with bit 2 set and one with bit 2 clear.

// File: rtl/serial_clock_nvram.sv
module serial_clock_nvram #(
  parameter int         RAM_WORDS   = 32,
  parameter logic [7:0] STATUS_INIT = 8'h90,
  parameter logic [7:0] CTRL_INIT   = 8'h00,
  parameter logic [7:0] INIT_SEC    = 8'h00,
  parameter logic [7:0] INIT_MIN    = 8'h00,
  parameter logic [7:0] INIT_HOUR   = 8'h00,
  parameter logic [7:0] INIT_DAY    = 8'h01,
  parameter logic [7:0] INIT_MONTH  = 8'h01,
  parameter logic [7:0] INIT_YEAR   = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en,
  input  logic sec_tick,
  input  logic pwr_evt,
  output logic irq
);
  localparam int AW = $clog2(RAM_WORDS);

  logic       sclk_q;
  logic [4:0] phase;
  logic [7:0] cmd, val, shadow, status;
  logic       rd_ok;
  logic [7:0] ram [RAM_WORDS];
  logic [7:0] t_sec, t_min, t_hour, t_day, t_mon, t_yr;
  logic [7:0] sel_byte;

  wire       fall   = ce & sclk_q & ~sclk;
  wire [7:0] cmd_nx = {cmd[6:0], sdi};
  wire [7:0] val_nx = {val[6:0], sdi};
  wire       last   = fall && phase == 5'd15;
  wire       do_wr  = last && cmd[7:5] == 3'b100;
  wire       do_ack = last && cmd == 8'hB1 && val_nx[2];

  function automatic logic readable(input logic [7:0] c);
    return c[7:5] == 3'b000 || c[7:4] == 4'h2 || c == 8'h30 || c == 8'h31;
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] base);
    if (v == top)          return base;
    else if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                   return v + 8'h01;
  endfunction

  always_comb begin
    sel_byte = 8'h00;
    if (cmd_nx[7:5] == 3'b000) sel_byte = ram[cmd_nx[AW-1:0]];
    else if (cmd_nx == 8'h30)  sel_byte = status;
    else if (cmd_nx == 8'h31)  sel_byte = CTRL_INIT;
    else begin
      case (cmd_nx)
        8'h20: sel_byte = t_sec;
        8'h21: sel_byte = t_min;
        8'h22: sel_byte = t_hour;
        8'h24: sel_byte = t_day;
        8'h25: sel_byte = t_mon;
        8'h26: sel_byte = t_yr;
        default: sel_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      phase  <= '0;
      cmd    <= '0;
      val    <= '0;
      shadow <= '0;
      rd_ok  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (!ce) begin
        phase <= '0;
        cmd   <= '0;
        val   <= '0;
        rd_ok <= 1'b0;
      end else if (fall) begin
        if (phase < 5'd8)       cmd <= cmd_nx;
        else if (phase < 5'd16) val <= val_nx;
        if (phase != 5'd16)     phase <= phase + 5'd1;
        if (phase == 5'd7) begin
          shadow <= sel_byte;
          rd_ok  <= readable(cmd_nx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_WORDS; i++) ram[i] <= 8'h00;
    end else if (do_wr) begin
      ram[cmd[AW-1:0]] <= val_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= STATUS_INIT;
    else        status <= (do_ack ? (status & 8'hE7) : status) | (pwr_evt ? 8'h08 : 8'h00);
  end

  wire c_s  = sec_tick && t_sec  == 8'h59;
  wire c_m  = c_s      && t_min  == 8'h59;
  wire c_h  = c_m      && t_hour == 8'h23;
  wire c_d  = c_h      && t_day  == 8'h31;
  wire c_mo = c_d      && t_mon  == 8'h12;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_sec <= INIT_SEC;  t_min <= INIT_MIN;   t_hour <= INIT_HOUR;
      t_day <= INIT_DAY;  t_mon <= INIT_MONTH; t_yr   <= INIT_YEAR;
    end else begin
      if (sec_tick) t_sec  <= bcd_step(t_sec,  8'h59, 8'h00);
      if (c_s)      t_min  <= bcd_step(t_min,  8'h59, 8'h00);
      if (c_m)      t_hour <= bcd_step(t_hour, 8'h23, 8'h00);
      if (c_h)      t_day  <= bcd_step(t_day,  8'h31, 8'h01);
      if (c_d)      t_mon  <= bcd_step(t_mon,  8'h12, 8'h01);
      if (c_mo)     t_yr   <= bcd_step(t_yr,   8'h99, 8'h00);
    end
  end

  assign sdo_en = ce & rd_ok & phase[3] & ~phase[4];
  assign sdo    = sdo_en & shadow[~phase[2:0]];
  assign irq    = status[4] | status[3];

  AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) phase <= 5'd16); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && $past(ce) && phase != $past(phase)) |-> phase == $past(phase) + 5'd1); // R1
  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (phase == 5'd0 && cmd == 8'h00 && !sdo_en)); // R2
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> (phase >= 5'd8 && phase <= 5'd15)); // R3
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && !pwr_evt) |=> !irq); // R6
  AST_TIME_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    t_sec <= 8'h59 && t_min <= 8'h59 && t_hour <= 8'h23 && t_sec[3:0] <= 4'h9 &&
    t_min[3:0] <= 4'h9 && t_hour[3:0] <= 4'h9 && t_day >= 8'h01 && t_day <= 8'h31 &&
    t_mon >= 8'h01 && t_mon <= 8'h12 && t_yr[3:0] <= 4'h9 && t_yr[7:4] <= 4'h9); // R9
endmodule

// File: tb/test_serial_clock_nvram.sv
module test_serial_clock_nvram;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sec_tick = 1'b0, pwr_evt = 1'b0;
  logic sdo, sdo_en, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_clock_nvram #(
    .INIT_SEC(8'h58), .INIT_MIN(8'h59), .INIT_HOUR(8'h23),
    .INIT_DAY(8'h31), .INIT_MONTH(8'h12), .INIT_YEAR(8'h99)
  ) i_serial_clock_nvram (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdo_en(sdo_en), .sec_tick(sec_tick), .pwr_evt(pwr_evt), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] v, input int nbits,
                      output logic [7:0] rd, output logic en_seen);
    logic [15:0] word = {c, v};
    rd = 8'h00;
    en_seen = 1'b0;
    @(negedge clk); ce = 1'b1; sclk = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = word[15-i]; sclk = 1'b1;
      repeat (2) @(negedge clk);
      if (i >= 8) begin
        rd = {rd[6:0], sdo};
        en_seen = en_seen | sdo_en;
      end else begin
        en_seen = en_seen | sdo_en;
      end
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    ce = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] dummy(input logic [7:0] x); return x; endfunction

  task automatic rd_cmd(input logic [7:0] c, input logic [7:0] exp, input string tag);
    logic [7:0] r; logic e;
    xfer(c, 8'h00, 16, r, e);
    chk(r, exp, tag);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk({7'd0, irq}, 8'h01, "R6 irq after reset");
    chk({7'd0, sdo_en}, 8'h00, "R3 sdo_en idle");
    rd_cmd(8'h30, 8'h90, "R5 status reset");
    rd_cmd(8'h31, 8'h00, "R5 control byte");
    rd_cmd(8'h07, 8'h00, "R5 ram reset");
  endtask

  task automatic t_ram;
    logic [7:0] r; logic e;
    xfer(8'h85, 8'hA7, 16, r, e);
    chk({7'd0, e}, 8'h00, "R3 no drive on write");
    rd_cmd(8'h05, 8'hA7, "R4 ram write/read");
    xfer(8'h80, 8'h3C, 16, r, e);
    xfer(8'h9F, 8'hC3, 16, r, e);
    rd_cmd(8'h00, 8'h3C, "R4 ram low end");
    rd_cmd(8'h1F, 8'hC3, "R4 ram high end");
    xfer(8'h00, 8'h00, 16, r, e);
    chk({7'd0, e}, 8'h01, "R3 drive on read");
  endtask

  task automatic t_abort;
    logic [7:0] r; logic e;
    xfer(8'h83, 8'h55, 15, r, e);
    rd_cmd(8'h03, 8'h00, "R2 aborted write");
    xfer(8'h83, 8'h66, 16, r, e);
    rd_cmd(8'h03, 8'h66, "R1 full frame after abort");
  endtask

  task automatic t_other;
    logic [7:0] r; logic e;
    xfer(8'h45, 8'hFF, 16, r, e);
    chk({7'd0, e}, 8'h00, "R8 unused cmd no drive");
    rd_cmd(8'h05, 8'hA7, "R8 unused cmd no write");
    rd_cmd(8'h23, 8'h00, "R8 cmd 0x23 zero");
    rd_cmd(8'h2A, 8'h00, "R8 cmd 0x2A zero");
  endtask

  task automatic t_time;
    rd_cmd(8'h20, 8'h58, "R7 seconds");
    rd_cmd(8'h21, 8'h59, "R7 minutes");
    rd_cmd(8'h22, 8'h23, "R7 hours");
    rd_cmd(8'h24, 8'h31, "R7 day");
    rd_cmd(8'h25, 8'h12, "R7 month");
    rd_cmd(8'h26, 8'h99, "R7 year");
    tick(1);
    rd_cmd(8'h20, 8'h59, "R9 seconds step");
    rd_cmd(8'h21, 8'h59, "R9 minutes hold");
    tick(1);
    rd_cmd(8'h20, 8'h00, "R9 seconds wrap");
    rd_cmd(8'h21, 8'h00, "R9 minutes wrap");
    rd_cmd(8'h22, 8'h00, "R9 hours wrap");
    rd_cmd(8'h24, 8'h01, "R9 day wrap");
    rd_cmd(8'h25, 8'h01, "R9 month wrap");
    rd_cmd(8'h26, 8'h00, "R9 year wrap");
    tick(10);
    rd_cmd(8'h20, 8'h10, "R9 bcd digit carry");
  endtask

  task automatic t_status;
    logic [7:0] r; logic e;
    xfer(8'hB1, 8'h04, 16, r, e);
    chk({7'd0, irq}, 8'h00, "R6 ack drops irq");
    rd_cmd(8'h30, 8'h80, "R6 status after ack");
    @(negedge clk); pwr_evt = 1'b1;
    @(negedge clk); pwr_evt = 1'b0;
    chk({7'd0, irq}, 8'h01, "R6 event raises irq");
    rd_cmd(8'h30, 8'h88, "R6 status after event");
    xfer(8'hB1, 8'hFB, 16, r, e);
    rd_cmd(8'h30, 8'h88, "R6 ack without bit2 ignored");
    xfer(8'hB1, 8'h04, 16, r, e);
    rd_cmd(8'h30, 8'h80, "R6 second ack");
    chk({7'd0, irq}, 8'h00, "R6 irq low");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ram();
    t_abort();
    t_other();
    t_time();
    t_status();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule